// File: doc/BRIEF.md
# Transmit Mailbox Priority Status Tracker

This block keeps a small read-only status word for a bank of transmit mailboxes. The word tells software which mailbox is the best place for its next frame. If any mailbox is free, that is the lowest-numbered free mailbox. If none is free, it is the active mailbox that would lose arbitration last: either the one with the largest arbitration value or the highest-numbered one, depending on an ordering mode bit. The word also carries a flag that says a free mailbox exists and a flag that says the contents are trustworthy.

Each time the transmit arbitration logic finishes a pass, it pulses a strobe. On that strobe the block captures the per-mailbox flags, the arbitration values, the mode bit and the mailbox limit into a snapshot. On the following clock edge it scans the snapshot and loads the result. Mailboxes that are currently on the bus, and mailboxes above the configured limit, take no part in the choice.

A CPU write to any mailbox control word makes the word untrustworthy until a clean pass completes. When no mailbox is free, a successful transmission reports its own mailbox number in the index.

Top module: `txmb_prio_status`

## Requirements
- R1: After reset the whole status word reads 0. The index sits in bits 22..16, the valid flag at bit 14 and the free-mailbox flag at bit 13, and every other bit always reads 0.
- R2: When a completed pass sees at least one eligible free mailbox, the free flag is 1 and the index is the lowest-numbered eligible free mailbox.
- R3: When no eligible free mailbox exists and the ordering mode is 0, the index is the eligible active mailbox with the greatest arbitration value. On equal values the lower mailbox number wins.
- R4: When no eligible free mailbox exists and the ordering mode is 1, the index is the highest-numbered eligible active mailbox.
- R5: A mailbox whose in-transmission flag is set is not eligible, whatever its other flags are.
- R6: Only mailboxes numbered up to min(NUM_MB-1, max_mb_cfg) are eligible. Higher-numbered mailboxes are ignored.
- R7: When tx_done is sampled while the free flag is 0 and no pass is completing, the index takes tx_done_mb at that edge. When the free flag is 1, tx_done leaves the index unchanged. A completing pass takes precedence over tx_done.
- R8: The snapshot is captured at the edge that samples arb_pass_done, and the pass completes at the next edge. Completion sets the valid flag to 1 unless cpu_ctrl_wr was sampled at any edge after the previous capture, up to and including the completion edge.
- R9: cpu_ctrl_wr sampled at an edge clears the valid flag at that edge. The flag stays 0 until a later pass completes cleanly.
- R10: A completed pass that finds no eligible mailbox at all reports index 0 with the free flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mb_active | input | NUM_MB | Per-mailbox: holds a frame waiting to send |
| mb_free | input | NUM_MB | Per-mailbox: inactive, free for a new frame |
| mb_sending | input | NUM_MB | Per-mailbox: frame currently on the bus |
| mb_prio | input | NUM_MB*PRIO_W | Per-mailbox arbitration values, mailbox i at bits i*PRIO_W upward |
| order_by_num | input | 1 | Ordering mode: 0 largest value, 1 highest number |
| max_mb_cfg | input | 7 | Highest mailbox number to consider |
| arb_pass_done | input | 1 | Arbitration pass finished, capture snapshot |
| tx_done | input | 1 | A frame was transmitted successfully |
| tx_done_mb | input | 7 | Mailbox number of that frame |
| cpu_ctrl_wr | input | 1 | CPU wrote a mailbox control word |
| status_word | output | 32 | Packed status word |

## Verification
The pass result appears two rising edges after arb_pass_done is presented. The first edge captures the snapshot and the second loads the scan result. A tx_done load and a valid-flag clear from cpu_ctrl_wr appear after a single edge. The bench drives inputs on falling edges and steps its own cycle model on each rising edge. It then compares every field of the word at the next falling edge, so every check looks at exactly the cycle in which a result is due.

// File: rtl/txmb_pkg.sv
// Package: shared widths and status-word field positions for the
// transmit mailbox priority tracker. Assumes at most 128 mailboxes.
package txmb_pkg;
    localparam int IDX_W     = 7;
    localparam int IDX_LSB   = 16;
    localparam int VALID_BIT = 14;
    localparam int FREE_BIT  = 13;

    // Pack the three fields into the 32-bit word, zero elsewhere.
    function automatic logic [31:0] pack_status(input logic [IDX_W-1:0] idx,
                                                input logic valid,
                                                input logic free);
        logic [31:0] w;
        w = '0;
        w[IDX_LSB +: IDX_W] = idx;
        w[VALID_BIT] = valid;
        w[FREE_BIT]  = free;
        return w;
    endfunction
endpackage

// File: rtl/txmb_snap.sv
// Snapshot register: captures mailbox flags, arbitration values, mode and
// the effective mailbox limit when an arbitration pass ends.
// Assumes capture is a single-cycle strobe; holds contents otherwise.
module txmb_snap
    import txmb_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int PRIO_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture,
    input  logic [NUM_MB-1:0]        act_i,
    input  logic [NUM_MB-1:0]        free_i,
    input  logic [NUM_MB-1:0]        send_i,
    input  logic [NUM_MB*PRIO_W-1:0] prio_i,
    input  logic                     by_num_i,
    input  logic [IDX_W-1:0]         max_mb_i,
    output logic [NUM_MB-1:0]        act_o,
    output logic [NUM_MB-1:0]        free_o,
    output logic [NUM_MB-1:0]        send_o,
    output logic [NUM_MB*PRIO_W-1:0] prio_o,
    output logic                     by_num_o,
    output logic [IDX_W-1:0]         limit_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_MB - 1);

    logic [IDX_W-1:0] limit_d;

    // Effective limit is the smaller of the configured field and the last mailbox.
    assign limit_d = (max_mb_i < LAST) ? max_mb_i : LAST;

    // Load all inputs on capture, hold otherwise.
    always_ff @(posedge clk) begin : snap_regs
        if (!rst_n) begin
            act_o    <= '0;
            free_o   <= '0;
            send_o   <= '0;
            prio_o   <= '0;
            by_num_o <= 1'b0;
            limit_o  <= '0;
        end else if (capture) begin
            act_o    <= act_i;
            free_o   <= free_i;
            send_o   <= send_i;
            prio_o   <= prio_i;
            by_num_o <= by_num_i;
            limit_o  <= limit_d;
        end
    end
endmodule

// File: rtl/txmb_scan.sv
// Combinational scan over the snapshot: finds the lowest eligible free
// mailbox, the eligible active mailbox with the largest value (ties to
// the lower number) and the highest-numbered eligible active mailbox.
// Assumes NUM_MB <= 128. Nothing found gives index 0.
module txmb_scan
    import txmb_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int PRIO_W = 8
) (
    input  logic [NUM_MB-1:0]        act,
    input  logic [NUM_MB-1:0]        free,
    input  logic [NUM_MB-1:0]        send,
    input  logic [NUM_MB*PRIO_W-1:0] prio,
    input  logic                     by_num,
    input  logic [IDX_W-1:0]         limit,
    output logic                     found_free,
    output logic [IDX_W-1:0]         pick_idx
);
    logic [NUM_MB-1:0] elig;
    logic [IDX_W-1:0]  free_idx, best_idx, high_idx;
    logic [PRIO_W-1:0] best_val;
    logic              any_cand;

    // Per-mailbox eligibility: within the limit and not on the bus.
    for (genvar g = 0; g < NUM_MB; g++) begin : g_elig
        assign elig[g] = (IDX_W'(g) <= limit) && !send[g];
    end

    // Walk the mailboxes once, keeping the three running selections.
    always_comb begin : scan_walk
        found_free = 1'b0;
        free_idx   = '0;
        any_cand   = 1'b0;
        best_idx   = '0;
        best_val   = '0;
        high_idx   = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (elig[i]) begin
                if (free[i] && !found_free) begin
                    found_free = 1'b1;
                    free_idx   = IDX_W'(i);
                end
                if (act[i]) begin
                    if (!any_cand || prio[i*PRIO_W +: PRIO_W] > best_val) begin
                        best_val = prio[i*PRIO_W +: PRIO_W];
                        best_idx = IDX_W'(i);
                    end
                    any_cand = 1'b1;
                    high_idx = IDX_W'(i);
                end
            end
        end
    end

    // Free mailbox wins, otherwise the mode picks the ordering.
    assign pick_idx = found_free ? free_idx : (by_num ? high_idx : best_idx);
endmodule

// File: rtl/txmb_prio_status.sv
// Top: transmit mailbox priority status word. Captures a snapshot on
// arb_pass_done, loads the scan result one edge later and sets the valid
// flag unless a CPU control write hit the pass. A successful transmit
// updates the index while no free mailbox is reported.
// Assumes single-cycle strobes and NUM_MB <= 128.
module txmb_prio_status
    import txmb_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int PRIO_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_MB-1:0]        mb_active,
    input  logic [NUM_MB-1:0]        mb_free,
    input  logic [NUM_MB-1:0]        mb_sending,
    input  logic [NUM_MB*PRIO_W-1:0] mb_prio,
    input  logic                     order_by_num,
    input  logic [IDX_W-1:0]         max_mb_cfg,
    input  logic                     arb_pass_done,
    input  logic                     tx_done,
    input  logic [IDX_W-1:0]         tx_done_mb,
    input  logic                     cpu_ctrl_wr,
    output logic [31:0]              status_word
);
    logic [NUM_MB-1:0]        s_act, s_free, s_send;
    logic [NUM_MB*PRIO_W-1:0] s_prio;
    logic                     s_by_num;
    logic [IDX_W-1:0]         s_limit;
    logic                     scan_free;
    logic [IDX_W-1:0]         scan_idx;

    logic                     pend_q, pass_dirty_q, dirty_q;
    logic [IDX_W-1:0]         idx_q;
    logic                     valid_q, free_q;

    txmb_snap #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W)) i_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (arb_pass_done),
        .act_i    (mb_active),
        .free_i   (mb_free),
        .send_i   (mb_sending),
        .prio_i   (mb_prio),
        .by_num_i (order_by_num),
        .max_mb_i (max_mb_cfg),
        .act_o    (s_act),
        .free_o   (s_free),
        .send_o   (s_send),
        .prio_o   (s_prio),
        .by_num_o (s_by_num),
        .limit_o  (s_limit)
    );

    txmb_scan #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W)) i_scan (
        .act        (s_act),
        .free       (s_free),
        .send       (s_send),
        .prio       (s_prio),
        .by_num     (s_by_num),
        .limit      (s_limit),
        .found_free (scan_free),
        .pick_idx   (scan_idx)
    );

    // Track the pending pass and whether a CPU write touched it.
    always_ff @(posedge clk) begin : pass_track
        if (!rst_n) begin
            pend_q       <= 1'b0;
            pass_dirty_q <= 1'b0;
            dirty_q      <= 1'b0;
        end else if (arb_pass_done) begin
            pend_q       <= 1'b1;
            pass_dirty_q <= dirty_q | cpu_ctrl_wr;
            dirty_q      <= 1'b0;
        end else begin
            pend_q       <= 1'b0;
            dirty_q      <= dirty_q | cpu_ctrl_wr;
        end
    end

    // Status fields: pass result first, then transmit-done and CPU-write updates.
    always_ff @(posedge clk) begin : status_regs
        if (!rst_n) begin
            idx_q   <= '0;
            valid_q <= 1'b0;
            free_q  <= 1'b0;
        end else if (pend_q) begin
            idx_q   <= scan_idx;
            free_q  <= scan_free;
            valid_q <= !pass_dirty_q && !cpu_ctrl_wr;
        end else begin
            if (tx_done && !free_q) begin
                idx_q <= tx_done_mb;
            end
            if (cpu_ctrl_wr) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign status_word = pack_status(idx_q, valid_q, free_q);

    AST_WR_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ctrl_wr |=> !status_word[VALID_BIT]); // R9
    AST_VALID_FROM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $past(pend_q)); // R8
    AST_TXDONE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !free_q && !pend_q) |=> (idx_q == $past(tx_done_mb))); // R7
    AST_IDX_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> (idx_q <= $past(s_limit))); // R6
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[31:23] == '0) && (status_word[15] == 1'b0) && (status_word[12:0] == '0)); // R1
endmodule

// File: tb/test_txmb_prio_status.sv
module test_txmb_prio_status;
    localparam int N = 16;
    localparam int W = 8;
    localparam int IW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   act = '0, fre = '0, snd = '0;
    logic [N*W-1:0] prio = '0;
    logic           mode = 1'b0;
    logic [IW-1:0]  maxmb = 7'd127;
    logic           arbdone = 1'b0, txdone = 1'b0, wr = 1'b0;
    logic [IW-1:0]  txmb = '0;
    logic [31:0]    status_word;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // model state
    logic [N-1:0]   m_act = '0, m_fre = '0, m_snd = '0;
    logic [N*W-1:0] m_prio = '0;
    logic           m_mode = 1'b0;
    logic [IW-1:0]  m_lim = '0;
    logic           m_pend = 1'b0, m_pdirty = 1'b0, m_dirty = 1'b0;
    logic [IW-1:0]  e_idx = '0;
    logic           e_valid = 1'b0, e_free = 1'b0;
    string          tag_idx = "R1", tag_valid = "R1";

    always #4 clk = ~clk;

    txmb_prio_status #(.NUM_MB(N), .PRIO_W(W)) i_txmb_prio_status (
        .clk(clk), .rst_n(rst_n), .mb_active(act), .mb_free(fre),
        .mb_sending(snd), .mb_prio(prio), .order_by_num(mode),
        .max_mb_cfg(maxmb), .arb_pass_done(arbdone), .tx_done(txdone),
        .tx_done_mb(txmb), .cpu_ctrl_wr(wr), .status_word(status_word)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0d expected=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Reference choice from the requirements: returns {free_flag, index}.
    function automatic logic [IW:0] ref_pick(input logic [N-1:0] a, input logic [N-1:0] f,
                                             input logic [N-1:0] s, input logic [N*W-1:0] p,
                                             input logic md, input logic [IW-1:0] lim);
        int lowfree = -1, best = -1, high = -1;
        int bestv = -1;
        for (int i = 0; i < N; i++) begin
            if (i <= int'(lim) && !s[i]) begin
                if (f[i] && lowfree < 0) lowfree = i;
                if (a[i]) begin
                    high = i;
                    if (int'(p[i*W +: W]) > bestv) begin
                        bestv = int'(p[i*W +: W]);
                        best = i;
                    end
                end
            end
        end
        if (lowfree >= 0) return {1'b1, IW'(lowfree)};
        if (md) return {1'b0, (high < 0) ? 7'd0 : IW'(high)};
        return {1'b0, (best < 0) ? 7'd0 : IW'(best)};
    endfunction

    // Step the cycle model at a rising edge.
    task automatic model_edge();
        logic [IW:0] r;
        if (m_pend) begin
            r = ref_pick(m_act, m_fre, m_snd, m_prio, m_mode, m_lim);
            e_free = r[IW];
            e_idx = r[IW-1:0];
            e_valid = !m_pdirty && !wr;
            tag_idx = e_free ? "R2" : (m_mode ? "R4" : "R3");
            tag_valid = "R8";
        end else begin
            if (txdone && !e_free) begin
                e_idx = txmb;
                tag_idx = "R7";
            end
            if (wr) begin
                e_valid = 1'b0;
                tag_valid = "R9";
            end
        end
        if (arbdone) begin
            m_act = act; m_fre = fre; m_snd = snd; m_prio = prio; m_mode = mode;
            m_lim = (maxmb < IW'(N-1)) ? maxmb : IW'(N-1);
            m_pend = 1'b1;
            m_pdirty = m_dirty | wr;
            m_dirty = 1'b0;
        end else begin
            m_pend = 1'b0;
            m_dirty = m_dirty | wr;
        end
    endtask

    task automatic compare_all();
        chk(tag_idx, int'(status_word[22:16]), int'(e_idx));
        chk(tag_valid, int'(status_word[14]), int'(e_valid));
        chk("R2", int'(status_word[13]), int'(e_free));
        chk("R1", int'({status_word[31:23], status_word[15], status_word[12:0]}), 0);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic clear_mbs();
        act = '0; fre = '0; snd = '0; prio = '0;
    endtask

    task automatic run_pass();
        arbdone = 1'b1;
        tick();
        arbdone = 1'b0;
        tick();
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", int'(status_word), 0);
        rst_n = 1'b1;
        tick();
        chk("R1", int'(status_word), 0);

        // R2: lowest free wins
        clear_mbs(); act = '1; fre[9] = 1'b1; fre[5] = 1'b1; act[9] = 1'b0; act[5] = 1'b0;
        run_pass();
        chk("R2", int'(status_word[22:16]), 5);
        chk("R2", int'(status_word[13]), 1);
        chk("R8", int'(status_word[14]), 1);

        // R7: free flag set, transmit done ignored
        txdone = 1'b1; txmb = 7'd3; tick(); txdone = 1'b0;
        chk("R7", int'(status_word[22:16]), 5);

        // R3: tie on largest value resolves to lower number
        clear_mbs(); mode = 1'b0;
        act[2] = 1'b1; act[6] = 1'b1; act[4] = 1'b1;
        prio[2*W +: W] = 8'd7; prio[6*W +: W] = 8'd7; prio[4*W +: W] = 8'd3;
        run_pass();
        chk("R3", int'(status_word[22:16]), 2);
        chk("R3", int'(status_word[13]), 0);

        // R7: free flag clear, transmit done loads index
        txdone = 1'b1; txmb = 7'd11; tick(); txdone = 1'b0;
        chk("R7", int'(status_word[22:16]), 11);

        // R4 and R5: highest number, sending mailbox excluded
        mode = 1'b1; act[10] = 1'b1; snd[10] = 1'b1; prio[10*W +: W] = 8'd255;
        run_pass();
        chk("R4", int'(status_word[22:16]), 6);
        mode = 1'b0;
        run_pass();
        chk("R5", int'(status_word[22:16]), 2);

        // R6: limit hides free mailbox 8
        clear_mbs(); maxmb = 7'd3; fre[8] = 1'b1;
        act[1] = 1'b1; act[3] = 1'b1; prio[1*W +: W] = 8'd1; prio[3*W +: W] = 8'd5;
        run_pass();
        chk("R6", int'(status_word[22:16]), 3);
        chk("R6", int'(status_word[13]), 0);

        // R10: nothing eligible
        clear_mbs(); maxmb = 7'd127; snd[0] = 1'b1; act[0] = 1'b1;
        run_pass();
        chk("R10", int'(status_word[22:16]), 0);
        chk("R10", int'(status_word[13]), 0);
        chk("R10", int'(status_word[14]), 1);

        // R9: write clears valid at once; R8: write in a pass keeps it clear
        wr = 1'b1; tick(); wr = 1'b0;
        chk("R9", int'(status_word[14]), 0);
        arbdone = 1'b1; tick(); arbdone = 1'b0; tick();
        chk("R8", int'(status_word[14]), 0);
        run_pass();
        chk("R8", int'(status_word[14]), 1);

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < N; i++) begin
                int k;
                k = int'($urandom % 4);
                act[i] = (k == 1) || (k == 2);
                snd[i] = (k == 2);
                fre[i] = (k == 0) && ($urandom % 3 == 0);
                prio[i*W +: W] = W'($urandom % 8);
            end
            mode = 1'($urandom);
            maxmb = ($urandom % 4 == 0) ? 7'd127 : IW'($urandom % 20);
            arbdone = ($urandom % 4 == 0);
            txdone = ($urandom % 5 == 0);
            txmb = IW'($urandom % N);
            wr = ($urandom % 10 == 0);
            tick();
        end
        arbdone = 1'b0; txdone = 1'b0; wr = 1'b0;
        tick();

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule